// File: doc/BRIEF.md
# Clock Failure Guard with Internal-Clock Switchover

This block watches the clock the system is currently running from and steps in when that clock stops. A slow sample window comes from dividing the always-running internal RC clock. Inside each window the guard looks for at least one falling edge of the monitored clock. If a window closes with no edge, the guard latches a sticky failure flag and raises an interrupt when interrupts are enabled. It also forces the clock-source indication to the internal clock, and it enters the fail-safe state.

Software leaves the fail-safe state in one of two ways. It can write the oscillator-control strobe, after which the selection follows the written source field. It can also request sleep. Monitoring continues afterwards, so a software-chosen secondary clock that later dies is caught the same way.

At reset the guard picks the starting source. A crystal primary with two-speed start-up active runs on the internal clock for a 1024-cycle start-up period and then moves to the primary. An external-clock or RC primary is selected at once. Turning the monitor on also forces two-speed start-up on.

Top module: `clkfail_guard`

## Requirements
- R1: The sample window is 64 internal-clock cycles long; it opens at cycle 0 of the divider and is checked at cycle 32. A failure is declared only at that check point, and only when the monitored clock has shown no falling edge since the window opened. The decision is delayed by two further cycles, so with the monitored clock stopped from reset `fail_flag` is still 0 after the 35th rising edge following reset release and is 1 after the 36th.
- R2: On a declared failure, in the same cycle, `fail_flag` becomes 1, `fs_active` becomes 1 and `clk_sel` shows the internal source. `clk_sel` codes are: 2'b00 primary, 2'b01 secondary, 2'b10 internal.
- R3: `fail_irq` is high exactly when `fail_flag` is high and `int_en` is high.
- R4: `fail_flag` stays set until `flag_clr` is pulsed or reset is applied. Clearing the flag does not end the fail-safe state.
- R5: A pulse on `osc_wr` ends the fail-safe state one cycle later. `clk_sel` then follows `osc_sel` (2'b00 primary, 2'b01 secondary, 2'b1x internal), and `fail_flag` is left unchanged.
- R6: A rising edge of `sleep_req` ends the fail-safe state one cycle later, and `clk_sel` returns to the last source software selected.
- R7: After reset with `prim_type` = 2'b00 (crystal) and two-speed start-up active, `clk_sel` shows internal through the 1023rd rising edge and primary from the 1024th rising edge on.
- R8: After reset with `prim_type` = 2'b01 (external clock) or 2'b10 (RC), `clk_sel` shows primary straight away.
- R9: After a write selects the secondary source, a stop of the monitored clock is detected again. The guard re-enters fail-safe and sets the flag within two sample windows.
- R10: With `mon_en` low, no failure is ever declared, and `two_speed` simply follows `ts_cfg`.
- R11: With `mon_en` high, `two_speed` is 1 whatever the value of `ts_cfg`, and a crystal primary goes through the start-up period.
- R12: While `sleep_req` is high, no failure is declared even if the monitored clock is stopped. Checking resumes once sleep ends.
- R13: A monitored clock that keeps toggling never causes a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Always-running internal RC clock; clocks all logic except the edge toggle |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_clk | input | 1 | Monitored system clock (primary or secondary) |
| mon_en | input | 1 | Monitor enable configuration bit |
| ts_cfg | input | 1 | Two-speed start-up configuration bit |
| int_en | input | 1 | Oscillator-fail interrupt enable |
| prim_type | input | 2 | Primary source type: 00 crystal, 01 external clock, 10 RC |
| osc_wr | input | 1 | Oscillator-control write strobe |
| osc_sel | input | 2 | Source-select field written with `osc_wr` |
| sleep_req | input | 1 | Sleep active (level) |
| flag_clr | input | 1 | Software clear of the failure flag |
| clk_sel | output | 2 | Selected clock source indication |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| fail_irq | output | 1 | Oscillator-fail interrupt |
| fs_active | output | 1 | Fail-safe state active |
| two_speed | output | 1 | Two-speed start-up in effect |

## Verification
Each result is due a fixed number of internal-clock edges after its stimulus. A missing edge shows on the outputs three edges after the window's check point, which is edge 36 after reset release when the clock is stopped from reset. Write and sleep exits take one edge, the crystal start-up hand-over happens on edge 1024, and the interrupt and two-speed outputs follow their inputs within the same cycle. The bench drives inputs and samples outputs on the falling edge of the internal clock, counting rising edges from reset release. Exact-edge checks read the value one edge before and one edge after the expected change; window-based detections are checked after a margin longer than two sample windows.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;

    // Clock source codes shown on clk_sel and written through osc_sel
    typedef enum logic [1:0] {
        SRC_PRI = 2'b00,
        SRC_SEC = 2'b01,
        SRC_INT = 2'b10
    } src_e;

    // Primary oscillator kind, sampled during reset
    typedef enum logic [1:0] {
        PT_XTAL = 2'b00,
        PT_EXT  = 2'b01,
        PT_RC   = 2'b10
    } ptype_e;

    // Source-control state
    typedef enum logic [1:0] {
        ST_WARM = 2'b00,
        ST_RUN  = 2'b01,
        ST_SAFE = 2'b10
    } guard_state_e;

    // Map a written select field onto a source; any code with bit 1 set means internal
    function automatic src_e decode_sel(input logic [1:0] field);
        if (field[1]) begin
            return SRC_INT;
        end
        return field[0] ? SRC_SEC : SRC_PRI;
    endfunction

endpackage

// File: rtl/clkfail_sample_div.sv
// Sample-window generator.
// Divides the internal clock by DIV and produces two one-cycle enables:
// open_en at divider count 0 (window opens) and check_pt at count DIV/2.
// Assumes DIV is a power of two and at least 4.
module clkfail_sample_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_en,
    output logic check_pt
);
    localparam int CW   = $clog2(DIV);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] div_cnt;

    // Free-running divider counter, wraps after DIV cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt == CW'(DIV - 1)) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + CW'(1);
        end
    end

    assign open_en  = (div_cnt == '0);
    assign check_pt = (div_cnt == CW'(HALF));

endmodule

// File: rtl/clkfail_activity.sv
// Activity detector for the monitored clock.
// A toggle flop on the monitored clock's falling edge is carried into the
// internal-clock domain by XSYNC flops; any change seen there marks activity.
// The activity mark is cleared when a window opens and is tested at the check
// point; a quiet window produces a failure pulse that then passes DSYNC
// flops before leaving the module.
// Assumes the monitored clock period is at least twice the internal clock
// period, so that toggles are not lost when sampled.
module clkfail_activity #(
    parameter int XSYNC = 2,
    parameter int DSYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_clk,
    input  logic open_en,
    input  logic check_pt,
    input  logic check_en,
    input  logic restart,
    output logic fail_evt
);
    localparam int TW = XSYNC + 1;

    logic          tog;
    logic [TW-1:0] tog_sync;
    logic          edge_seen;
    logic          seen_mark;
    logic          armed;
    logic          fail_pulse;
    logic [DSYNC-1:0] dec_sync;

    // Toggle on every falling edge of the monitored clock
    always_ff @(negedge sys_clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else begin
            tog <= ~tog;
        end
    end

    // Synchronizer chain for the toggle, plus one history stage for edge detection
    always_ff @(posedge clk) begin
        tog_sync <= {tog_sync[TW-2:0], tog};
    end

    assign edge_seen = tog_sync[TW-1] ^ tog_sync[TW-2];

    // Activity mark: cleared at window open, set by any detected toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_mark <= 1'b0;
        end else if (open_en) begin
            seen_mark <= edge_seen;
        end else if (edge_seen) begin
            seen_mark <= 1'b1;
        end
    end

    // Arming: a check is valid only for a window that opened while checking was on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!check_en || restart) begin
            armed <= 1'b0;
        end else if (open_en) begin
            armed <= 1'b1;
        end
    end

    // Failure decision at the check point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_pulse <= 1'b0;
        end else begin
            fail_pulse <= check_pt && armed && check_en && !restart && !seen_mark && !edge_seen;
        end
    end

    // Decision synchronizer stages toward the source-control state
    generate
        if (DSYNC == 1) begin : g_dec_one
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dec_sync <= '0;
                end else begin
                    dec_sync <= fail_pulse;
                end
            end
        end else begin : g_dec_many
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dec_sync <= '0;
                end else begin
                    dec_sync <= {dec_sync[DSYNC-2:0], fail_pulse};
                end
            end
        end
    endgenerate

    assign fail_evt = dec_sync[DSYNC-1];

    // A failure pulse needs the window to have been armed one cycle earlier
    AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse && $past(rst_n) |-> $past(armed) && !$past(seen_mark)); // R1

endmodule

// File: rtl/clkfail_ost.sv
// Start-up period counter.
// Counts internal-clock cycles while run is high and flags done on the
// last cycle of an OST_LEN-cycle period; restarts from zero whenever run drops.
module clkfail_ost #(
    parameter int OST_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int OW = $clog2(OST_LEN);

    logic [OW-1:0] ost_cnt;

    // Count up while running, hold at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ost_cnt <= '0;
        end else if (!done) begin
            ost_cnt <= ost_cnt + OW'(1);
        end
    end

    assign done = run && (ost_cnt == OW'(OST_LEN - 1));

endmodule

// File: rtl/clkfail_ctrl.sv
// Source-control state machine and failure flag.
// Chooses the starting state at reset, moves to fail-safe on a failure
// event, leaves it on a control write or sleep entry, keeps the software
// source selection, and holds the sticky failure flag.
module clkfail_ctrl
    import clkfail_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         warm_at_reset,
    input  logic         fail_evt,
    input  logic         ost_done,
    input  logic         osc_wr,
    input  logic [1:0]   osc_sel,
    input  logic         sleep_req,
    input  logic         flag_clr,
    output guard_state_e state,
    output src_e         sw_sel,
    output logic         fail_flag,
    output logic         fs_active,
    output logic [1:0]   clk_sel
);
    logic sleep_q;
    logic sleep_rise;
    logic enter_safe;

    assign sleep_rise = sleep_req && !sleep_q;
    assign enter_safe = (state == ST_RUN) && fail_evt && !osc_wr;

    // Previous sleep level, for entry detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b0;
        end else begin
            sleep_q <= sleep_req;
        end
    end

    // Software source selection, updated by every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_sel <= SRC_PRI;
        end else if (osc_wr) begin
            sw_sel <= decode_sel(osc_sel);
        end
    end

    // State transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= warm_at_reset ? ST_WARM : ST_RUN;
        end else begin
            case (state)
                ST_WARM: if (osc_wr || ost_done)    state <= ST_RUN;
                ST_RUN:  if (enter_safe)            state <= ST_SAFE;
                ST_SAFE: if (osc_wr || sleep_rise)  state <= ST_RUN;
                default:                            state <= ST_RUN;
            endcase
        end
    end

    // Sticky failure flag; a new failure takes precedence over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_flag <= 1'b0;
        end else if (enter_safe) begin
            fail_flag <= 1'b1;
        end else if (flag_clr) begin
            fail_flag <= 1'b0;
        end
    end

    assign fs_active = (state == ST_SAFE);
    assign clk_sel   = (state == ST_RUN) ? sw_sel : SRC_INT;

    AST_SAFE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_active) && $past(rst_n) |-> fail_flag); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(fail_flag) && !$past(flag_clr) |-> fail_flag); // R4

    AST_SAFE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs_active) && $past(rst_n) |-> $past(osc_wr) || $past(sleep_req)); // R5

    AST_WARM_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(state == ST_WARM) && (state != ST_WARM)
        |-> $past(ost_done) || $past(osc_wr)); // R7

endmodule

// File: rtl/clkfail_guard.sv
// Clock failure guard, top level.
// Ties the sample-window divider, the activity detector, the start-up
// counter and the source-control state machine together. Everything except
// the monitored clock's toggle flop runs on the internal RC clock.
module clkfail_guard
    import clkfail_pkg::*;
#(
    parameter int DIV     = 64,
    parameter int OST_LEN = 1024,
    parameter int XSYNC   = 2,
    parameter int DSYNC   = 2
) (
    input  logic       clk_rc,
    input  logic       rst_n,
    input  logic       sys_clk,
    input  logic       mon_en,
    input  logic       ts_cfg,
    input  logic       int_en,
    input  logic [1:0] prim_type,
    input  logic       osc_wr,
    input  logic [1:0] osc_sel,
    input  logic       sleep_req,
    input  logic       flag_clr,
    output logic [1:0] clk_sel,
    output logic       fail_flag,
    output logic       fail_irq,
    output logic       fs_active,
    output logic       two_speed
);
    localparam int SLEEP_GUARD = DSYNC + 2;
    localparam int SGW         = $clog2(SLEEP_GUARD + 1);

    logic         open_en;
    logic         check_pt;
    logic         check_en;
    logic         fail_evt;
    logic         ost_done;
    logic         warm_at_reset;
    guard_state_e state;
    src_e         sw_sel;
    logic [SGW-1:0] sleep_cnt;

    assign two_speed     = ts_cfg || mon_en;
    assign warm_at_reset = two_speed && (prim_type == PT_XTAL);
    assign check_en      = mon_en && (state == ST_RUN) && !sleep_req && (sw_sel != SRC_INT);
    assign fail_irq      = fail_flag && int_en;

    clkfail_sample_div #(
        .DIV (DIV)
    ) u_div (
        .clk      (clk_rc),
        .rst_n    (rst_n),
        .open_en  (open_en),
        .check_pt (check_pt)
    );

    clkfail_activity #(
        .XSYNC (XSYNC),
        .DSYNC (DSYNC)
    ) u_act (
        .clk      (clk_rc),
        .rst_n    (rst_n),
        .sys_clk  (sys_clk),
        .open_en  (open_en),
        .check_pt (check_pt),
        .check_en (check_en),
        .restart  (osc_wr),
        .fail_evt (fail_evt)
    );

    clkfail_ost #(
        .OST_LEN (OST_LEN)
    ) u_ost (
        .clk   (clk_rc),
        .rst_n (rst_n),
        .run   (state == ST_WARM),
        .done  (ost_done)
    );

    clkfail_ctrl u_ctrl (
        .clk           (clk_rc),
        .rst_n         (rst_n),
        .warm_at_reset (warm_at_reset),
        .fail_evt      (fail_evt),
        .ost_done      (ost_done),
        .osc_wr        (osc_wr),
        .osc_sel       (osc_sel),
        .sleep_req     (sleep_req),
        .flag_clr      (flag_clr),
        .state         (state),
        .sw_sel        (sw_sel),
        .fail_flag     (fail_flag),
        .fs_active     (fs_active),
        .clk_sel       (clk_sel)
    );

    // Cycles spent in sleep, saturating once in-flight decisions have drained
    always_ff @(posedge clk_rc) begin
        if (!rst_n || !sleep_req) begin
            sleep_cnt <= '0;
        end else if (sleep_cnt != SGW'(SLEEP_GUARD)) begin
            sleep_cnt <= sleep_cnt + SGW'(1);
        end
    end

    AST_FLAG_FROM_DETECT: assert property (@(posedge clk_rc) disable iff (!rst_n)
        $rose(fail_flag) && $past(rst_n) |-> $past(fail_evt)); // R1

    AST_SLEEP_QUIET: assert property (@(posedge clk_rc) disable iff (!rst_n)
        (sleep_cnt == SGW'(SLEEP_GUARD)) |-> !fail_evt); // R12

    AST_NO_DETECT_DISABLED: assert property (@(posedge clk_rc) disable iff (!rst_n)
        $past(rst_n) && !$past(mon_en) && !mon_en |-> !$rose(fail_flag)); // R10

endmodule

// File: tb/clkfail_guard_test.sv
module clkfail_guard_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_clk;
    logic       sys_run = 1'b1;
    logic       mon_en = 1'b1;
    logic       ts_cfg = 1'b0;
    logic       int_en = 1'b1;
    logic [1:0] prim_type = 2'b01;
    logic       osc_wr = 1'b0;
    logic [1:0] osc_sel = 2'b00;
    logic       sleep_req = 1'b0;
    logic       flag_clr = 1'b0;
    logic [1:0] clk_sel;
    logic       fail_flag;
    logic       fail_irq;
    logic       fs_active;
    logic       two_speed;

    int n_vec = 0;
    int n_bad = 0;

    clkfail_guard uut (
        .clk_rc    (clk),
        .rst_n     (rst_n),
        .sys_clk   (sys_clk),
        .mon_en    (mon_en),
        .ts_cfg    (ts_cfg),
        .int_en    (int_en),
        .prim_type (prim_type),
        .osc_wr    (osc_wr),
        .osc_sel   (osc_sel),
        .sleep_req (sleep_req),
        .flag_clr  (flag_clr),
        .clk_sel   (clk_sel),
        .fail_flag (fail_flag),
        .fail_irq  (fail_irq),
        .fs_active (fs_active),
        .two_speed (two_speed)
    );

    // 125 MHz internal clock
    always #4 clk = ~clk;

    // Monitored clock, 20 ns period, edges kept off the internal clock edges
    initial begin
        sys_clk = 1'b0;
        #1;
        forever begin
            #10;
            if (sys_run) sys_clk = ~sys_clk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge
    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic men, input logic tsc, input logic [1:0] pt, input logic run);
        @(negedge clk);
        rst_n = 1'b0;
        mon_en = men;
        ts_cfg = tsc;
        prim_type = pt;
        sys_run = run;
        osc_wr = 1'b0;
        sleep_req = 1'b0;
        flag_clr = 1'b0;
        for (int i = 0; i < 6; i++) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset(1'b1, 1'b0, 2'b01, 1'b1);
        chk("R8 clk_sel after reset ext", clk_sel, 0);
        chk("R2 fail_flag reset", fail_flag, 0);
        chk("R2 fs_active reset", fs_active, 0);
        chk("R3 fail_irq reset", fail_irq, 0);
        chk("R11 two_speed forced", two_speed, 1);
        wait_edges(300);
        chk("R13 running clock no fail", fs_active, 0);
        chk("R13 running clock no flag", fail_flag, 0);
    endtask

    task automatic t_stop_exact();
        int_en = 1'b1;
        do_reset(1'b1, 1'b0, 2'b01, 1'b0);
        wait_edges(35);
        chk("R1 no flag before edge 36", fail_flag, 0);
        chk("R1 no fail-safe before edge 36", fs_active, 0);
        wait_edges(1);
        chk("R1 flag at edge 36", fail_flag, 1);
        chk("R2 internal selected", clk_sel, 2);
        chk("R2 fail-safe active", fs_active, 1);
        chk("R3 irq with enable", fail_irq, 1);
    endtask

    task automatic t_irq_sticky();
        int_en = 1'b0;
        #1;
        chk("R3 irq masked", fail_irq, 0);
        wait_edges(50);
        chk("R4 flag holds", fail_flag, 1);
        flag_clr = 1'b1;
        wait_edges(1);
        flag_clr = 1'b0;
        chk("R4 flag cleared", fail_flag, 0);
        chk("R4 fail-safe kept after clear", fs_active, 1);
    endtask

    task automatic t_write_exit();
        sys_run = 1'b1;
        osc_sel = 2'b01;
        osc_wr = 1'b1;
        wait_edges(1);
        osc_wr = 1'b0;
        chk("R5 clk_sel follows write", clk_sel, 1);
        chk("R5 fail-safe ended", fs_active, 0);
        wait_edges(300);
        chk("R13 secondary running no fail", fs_active, 0);
        chk("R13 secondary running no flag", fail_flag, 0);
    endtask

    task automatic t_secondary_fail();
        int_en = 1'b1;
        sys_run = 1'b0;
        wait_edges(200);
        chk("R9 secondary fail detected", fs_active, 1);
        chk("R9 internal selected", clk_sel, 2);
        chk("R9 flag set", fail_flag, 1);
        chk("R3 irq on second failure", fail_irq, 1);
    endtask

    task automatic t_sleep();
        flag_clr = 1'b1;
        wait_edges(1);
        flag_clr = 1'b0;
        sleep_req = 1'b1;
        wait_edges(1);
        chk("R6 sleep ends fail-safe", fs_active, 0);
        chk("R6 back to software source", clk_sel, 1);
        wait_edges(300);
        chk("R12 no fail during sleep", fs_active, 0);
        chk("R12 no flag during sleep", fail_flag, 0);
        sleep_req = 1'b0;
        wait_edges(200);
        chk("R12 checking resumes after sleep", fs_active, 1);
    endtask

    task automatic t_xtal_warm();
        do_reset(1'b1, 1'b0, 2'b00, 1'b1);
        chk("R11 two_speed forced by enable", two_speed, 1);
        chk("R7 internal at start", clk_sel, 2);
        wait_edges(1023);
        chk("R7 internal through edge 1023", clk_sel, 2);
        chk("R7 no fail-safe in warm-up", fs_active, 0);
        wait_edges(1);
        chk("R7 primary at edge 1024", clk_sel, 0);
        wait_edges(300);
        chk("R13 primary running after warm-up", fs_active, 0);
    endtask

    task automatic t_rc_primary();
        do_reset(1'b1, 1'b1, 2'b10, 1'b1);
        chk("R8 rc primary immediate", clk_sel, 0);
        wait_edges(1);
        chk("R8 rc primary after edge 1", clk_sel, 0);
    endtask

    task automatic t_disabled();
        do_reset(1'b0, 1'b0, 2'b00, 1'b0);
        chk("R10 no warm-up when off", clk_sel, 0);
        chk("R10 two_speed follows cfg 0", two_speed, 0);
        wait_edges(300);
        chk("R10 no fail when disabled", fail_flag, 0);
        chk("R10 no fail-safe when disabled", fs_active, 0);
        ts_cfg = 1'b1;
        #1;
        chk("R10 two_speed follows cfg 1", two_speed, 1);
        do_reset(1'b0, 1'b1, 2'b00, 1'b1);
        chk("R10 cfg alone warms crystal", clk_sel, 2);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_stop_exact();
        t_irq_sticky();
        t_write_exit();
        t_secondary_fail();
        t_sleep();
        t_xtal_warm();
        t_rc_primary();
        t_disabled();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule